// File: doc/BRIEF.md
# Flash Command Interface Controller

This block puts a command-driven front end, like the one on a block-erasable flash device, in front of a small simulated cell array. The host writes single bytes over a simple bus. Each byte is read as a command, or as the data byte that a command expects next. Reads go through the same bus. Whether a read returns array contents or a status byte depends on a read mode. The read mode keeps its value until a command changes it.

Program and erase jobs run on an internal job timer. The timer models how long the cell operation takes. While a job runs, the block rejects commands that are not legal in that state. It records failures in sticky status bits. It also refuses to start a job when the programming supply is reported out of range. An erase can be suspended so that other blocks can be read, and then resumed.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array, every array byte reads 0xFF, and the status byte is 0x80.
- R2: Writing 0x70 in the idle state switches reads to the status byte for every address. Writing 0xFF switches reads to array data. The mode holds across any number of cycles without writes.
- R3: The status byte is laid out as follows. Bit 7 is 1 when no job is running and 0 while a program or erase job runs. Bit 6 is the suspend flag. Bit 5 is erase failure. Bit 4 is program failure. Bit 3 is supply low. Bits 2:0 always read 0.
- R4: Writing 0x40 arms a program. The next write supplies the address and the data. With the supply good, the job stays busy for PROG_CYC cycles, and the byte then becomes its old value ANDed with the data. Arming switches the read mode to status.
- R5: While a program job runs, every command except 0x70 is ignored. This includes 0xFF, 0x20 and 0x50.
- R6: If the supply is low when the program data is written, bit 3 is set, no job starts, and the array is unchanged.
- R7: Writing 0x20 and then 0xD0 erases the block selected by the top BLK_W address bits of the 0xD0 write. The job is busy for ERASE_CYC cycles, and every byte of that block then reads 0xFF.
- R8: If the supply is low when 0xD0 confirms an erase, bits 5 and 3 are both set and nothing is erased.
- R9: If any byte other than 0xD0 follows 0x20, the erase is aborted and bits 5 and 4 are both set.
- R10: If fault_inject is high on the final cycle of a job, bit 4 is set for a program job and bit 5 for an erase job. The array is still updated.
- R11: Bits 5:3 stay set until 0x50 is written in the idle state, which clears all three.
- R12: Writing 0xB0 during an erase freezes the remaining erase time. Bits 7 and 6 read 1 while suspended. Only 0xFF, 0x70 and 0xD0 are honoured in this state. In array mode, reads of the suspended block return the status byte. 0xD0 resumes the erase, clears bit 6 and selects status mode.
- R13: When a job finishes, reads keep returning the status byte until 0xFF is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Write strobe: the data byte is taken as a command or as program data |
| host_addr | input | ADDR_W | Byte address for reads, program data and erase block selection |
| host_wdata | input | 8 | Command or data byte |
| host_rdata | output | 8 | Array byte or status byte, depending on the read mode |
| vpp_ok | input | 1 | Programming supply within range |
| fault_inject | input | 1 | Makes the job that ends in this cycle report a failure |

## Verification
The bench sends command streams that reach every state. These cover clean program and erase runs, repeated programming of the same byte, and both job types with the supply low, with an injected fault, and with a broken erase sequence. Each of these gives a distinct status code, so a wrong failure bit shows up at once. Illegal bytes are written during programming and during suspend, and the read mode that follows shows whether any of them took effect. The suspend scenario reads the suspended block and a neighbouring block, and it times the resumed erase. Together these separate a correct frozen timer from a timer that restarts or keeps running.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSET,
        ST_ESET,
        ST_PROG,
        ST_ERASE,
        ST_SUSP
    } fcc_state_e;

    typedef enum logic {
        RM_ARRAY,
        RM_STATUS
    } fcc_rmode_e;

    localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_READ_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR       = 8'h50;
    localparam logic [7:0] OP_PROG_ARM    = 8'h40;
    localparam logic [7:0] OP_ERASE_ARM   = 8'h20;
    localparam logic [7:0] OP_CONFIRM     = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;

    localparam int FAIL_ERASE = 2;
    localparam int FAIL_PROG  = 1;
    localparam int FAIL_VPP   = 0;
endpackage

// File: rtl/fcc_job_timer.sv
module fcc_job_timer #(
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_prog,
    input  logic start_erase,
    input  logic hold,
    output logic done,
    output logic busy
);
    localparam int MAXC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int CNT_W = $clog2(MAXC) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
    } tmr_t;

    tmr_t t_d, t_q;

    assign done = t_q.run && !hold && (t_q.cnt == '0);
    assign busy = t_q.run;

    always_comb begin
        t_d = t_q;
        if (start_prog) begin
            t_d.cnt = CNT_W'(PROG_CYC - 1);
            t_d.run = 1'b1;
        end else if (start_erase) begin
            t_d.cnt = CNT_W'(ERASE_CYC - 1);
            t_d.run = 1'b1;
        end else if (t_q.run && !hold) begin
            if (t_q.cnt == '0) t_d.run = 1'b0;
            else               t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assert_busy_ends_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));
    assert_hold_freezes_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && $past(busy) && !$past(start_prog) && !$past(start_erase)) |-> busy);
endmodule

// File: rtl/fcc_cell_array.sv
module fcc_cell_array #(
    parameter int ADDR_W = 6,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [7:0]        prog_data,
    input  logic              erase_en,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int OFF_W = ADDR_W - BLK_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (erase_en && ((i >> OFF_W) == int'(erase_blk))) mem_d[i] = 8'hFF;
        end
        if (prog_en) mem_d[prog_addr] = mem_q[prog_addr] & prog_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= 8'hFF;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];

    assert_erase_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(erase_en) && (rd_addr[ADDR_W-1 -: BLK_W] == $past(erase_blk))) |-> (rd_data == 8'hFF));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
    parameter int ADDR_W    = 6,
    parameter int BLK_W     = 2,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              vpp_ok,
    input  logic              fault_inject
);
    import fcc_pkg::*;

    typedef struct packed {
        fcc_state_e        st;
        fcc_rmode_e        rm;
        logic [2:0]        fails;
        logic [ADDR_W-1:0] paddr;
        logic [7:0]        pdata;
        logic [BLK_W-1:0]  blk;
    } ctl_t;

    ctl_t r_d, r_q;

    logic       start_prog, start_erase, job_done, job_busy;
    logic       prog_en, erase_en;
    logic [7:0] arr_rd, status;

    always_comb begin
        r_d         = r_q;
        start_prog  = 1'b0;
        start_erase = 1'b0;
        prog_en     = 1'b0;
        erase_en    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: if (host_we) begin
                case (host_wdata)
                    OP_READ_ARRAY:  r_d.rm = RM_ARRAY;
                    OP_READ_STATUS: r_d.rm = RM_STATUS;
                    OP_CLEAR:       r_d.fails = '0;
                    OP_PROG_ARM:    begin r_d.st = ST_PSET; r_d.rm = RM_STATUS; end
                    OP_ERASE_ARM:   begin r_d.st = ST_ESET; r_d.rm = RM_STATUS; end
                    default:        ;
                endcase
            end
            ST_PSET: if (host_we) begin
                r_d.rm = RM_STATUS;
                if (!vpp_ok) begin
                    r_d.fails[FAIL_VPP] = 1'b1;
                    r_d.st              = ST_IDLE;
                end else begin
                    r_d.paddr  = host_addr;
                    r_d.pdata  = host_wdata;
                    r_d.st     = ST_PROG;
                    start_prog = 1'b1;
                end
            end
            ST_ESET: if (host_we) begin
                r_d.rm = RM_STATUS;
                r_d.st = ST_IDLE;
                if (host_wdata != OP_CONFIRM) begin
                    r_d.fails[FAIL_ERASE] = 1'b1;
                    r_d.fails[FAIL_PROG]  = 1'b1;
                end else if (!vpp_ok) begin
                    r_d.fails[FAIL_ERASE] = 1'b1;
                    r_d.fails[FAIL_VPP]   = 1'b1;
                end else begin
                    r_d.blk     = host_addr[ADDR_W-1 -: BLK_W];
                    r_d.st      = ST_ERASE;
                    start_erase = 1'b1;
                end
            end
            ST_PROG: begin
                if (job_done) begin
                    prog_en = 1'b1;
                    r_d.st  = ST_IDLE;
                    if (fault_inject) r_d.fails[FAIL_PROG] = 1'b1;
                end
                if (host_we && host_wdata == OP_READ_STATUS) r_d.rm = RM_STATUS;
            end
            ST_ERASE: begin
                if (job_done) begin
                    erase_en = 1'b1;
                    r_d.st   = ST_IDLE;
                    if (fault_inject) r_d.fails[FAIL_ERASE] = 1'b1;
                end else if (host_we && host_wdata == OP_SUSPEND) begin
                    r_d.st = ST_SUSP;
                end
                if (host_we && host_wdata == OP_READ_STATUS) r_d.rm = RM_STATUS;
            end
            ST_SUSP: if (host_we) begin
                case (host_wdata)
                    OP_READ_ARRAY:  r_d.rm = RM_ARRAY;
                    OP_READ_STATUS: r_d.rm = RM_STATUS;
                    OP_CONFIRM:     begin r_d.st = ST_ERASE; r_d.rm = RM_STATUS; end
                    default:        ;
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.rm    <= RM_ARRAY;
        end else begin
            r_q <= r_d;
        end
    end

    fcc_job_timer #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .hold        (r_q.st == ST_SUSP),
        .done        (job_done),
        .busy        (job_busy)
    );

    fcc_cell_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) i_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (r_q.paddr),
        .prog_data (r_q.pdata),
        .erase_en  (erase_en),
        .erase_blk (r_q.blk),
        .rd_addr   (host_addr),
        .rd_data   (arr_rd)
    );

    assign status = {!(r_q.st == ST_PROG || r_q.st == ST_ERASE),
                     r_q.st == ST_SUSP, r_q.fails, 3'b000};

    always_comb begin
        if (r_q.rm == RM_STATUS)
            host_rdata = status;
        else if (r_q.st == ST_SUSP && host_addr[ADDR_W-1 -: BLK_W] == r_q.blk)
            host_rdata = status;
        else
            host_rdata = arr_rd;
    end

    assert_fail_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(r_q.fails) & ~r_q.fails)) |->
        $past(host_we && host_wdata == OP_CLEAR && r_q.st == ST_IDLE));
    assert_prog_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG) |=> (r_q.st == ST_PROG || r_q.st == ST_IDLE));
    assert_prog_vpp_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PSET && host_we && !vpp_ok) |=> (r_q.st == ST_IDLE && r_q.fails[FAIL_VPP]));
    assert_job_timer_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PROG || r_q.st == ST_ERASE) |-> job_busy);
    assert_suspend_entry_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_SUSP) |-> $past(r_q.st == ST_ERASE && host_we && host_wdata == OP_SUSPEND));
    assert_status_after_job_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(job_done) |-> (r_q.rm == RM_STATUS));
endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
    localparam int ADDR_W = 6;
    localparam int BLK_W  = 2;
    localparam int PCYC   = 4;
    localparam int ECYC   = 12;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int SHIFT  = ADDR_W - BLK_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [7:0]        host_wdata = '0;
    logic [7:0]        host_rdata;
    logic              vpp_ok = 1'b1;
    logic              fault_inject = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .vpp_ok(vpp_ok), .fault_inject(fault_inject)
    );

    // reference model: 0 idle, 1 prog armed, 2 erase armed, 3 programming, 4 erasing, 5 suspended
    int m_mem [DEPTH];
    int m_st, m_rm, m_fail, m_rem, m_pa, m_pd, m_blk;
    int vectors = 0, miscompares = 0;
    bit finished = 0;
    int sweep = 0;

    function automatic int m_status();
        int s = m_fail;
        if (!(m_st == 3 || m_st == 4)) s |= 8'h80;
        if (m_st == 5) s |= 8'h40;
        return s;
    endfunction

    function automatic int m_read(int a);
        if (m_rm == 1) return m_status();
        if (m_st == 5 && (a >> SHIFT) == m_blk) return m_status();
        return m_mem[a];
    endfunction

    task automatic m_step(bit we, int a, int d);
        bit fin = (m_st == 3 || m_st == 4) && m_rem == 0;
        case (m_st)
            0: if (we) begin
                if (d == 8'hFF) m_rm = 0;
                else if (d == 8'h70) m_rm = 1;
                else if (d == 8'h50) m_fail = 0;
                else if (d == 8'h40) begin m_st = 1; m_rm = 1; end
                else if (d == 8'h20) begin m_st = 2; m_rm = 1; end
            end
            1: if (we) begin
                m_rm = 1;
                if (!vpp_ok) begin m_fail |= 8'h08; m_st = 0; end
                else begin m_pa = a; m_pd = d; m_rem = PCYC - 1; m_st = 3; end
            end
            2: if (we) begin
                m_rm = 1; m_st = 0;
                if (d != 8'hD0) m_fail |= 8'h30;
                else if (!vpp_ok) m_fail |= 8'h28;
                else begin m_blk = a >> SHIFT; m_rem = ECYC - 1; m_st = 4; end
            end
            3: begin
                if (fin) begin
                    m_mem[m_pa] &= m_pd;
                    if (fault_inject) m_fail |= 8'h10;
                    m_st = 0;
                end else m_rem--;
            end
            4: begin
                if (fin) begin
                    for (int i = 0; i < DEPTH; i++) if ((i >> SHIFT) == m_blk) m_mem[i] = 8'hFF;
                    if (fault_inject) m_fail |= 8'h20;
                    m_st = 0;
                end else begin
                    m_rem--;
                    if (we && d == 8'hB0) m_st = 5;
                end
            end
            5: if (we) begin
                if (d == 8'hFF) m_rm = 0;
                else if (d == 8'h70) m_rm = 1;
                else if (d == 8'hD0) begin m_st = 4; m_rm = 1; end
            end
            default: ;
        endcase
    endtask

    task automatic step(bit we, int a, int d, string tag);
        int exp;
        @(negedge clk);
        host_we = we; host_addr = a[ADDR_W-1:0]; host_wdata = d[7:0];
        #1;
        exp = m_read(a);
        vectors++;
        if (host_rdata !== exp[7:0]) begin
            miscompares++;
            $display("FAIL %s: addr %0h rdata %02h expected %02h", tag, a, host_rdata, exp[7:0]);
        end
        @(posedge clk);
        m_step(we, a, d);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) begin
            sweep = (sweep + 7) % DEPTH;
            step(0, sweep, 0, tag);
        end
    endtask

    task automatic wr(int a, int d, string tag);
        step(1, a, d, tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        m_st = 0; m_rm = 0; m_fail = 0; m_rem = 0; m_pa = 0; m_pd = 0; m_blk = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        idle(6, "R1");                              // reset: array mode, erased array
        wr(0, 8'h70, "R2"); idle(4, "R2 R3");       // status byte 0x80
        wr(0, 8'hFF, "R2"); idle(4, "R2");
        // program 0x05 with 0x3C, stray commands while busy
        wr(0, 8'h40, "R4"); wr(5, 8'h3C, "R4");
        wr(0, 8'hFF, "R5"); wr(0, 8'h20, "R5"); wr(0, 8'h50, "R5"); wr(0, 8'h70, "R5");
        idle(4, "R13");
        wr(0, 8'hFF, "R13"); step(0, 5, 0, "R4");
        wr(0, 8'h40, "R4"); wr(5, 8'hF0, "R4"); idle(6, "R4");
        wr(0, 8'hFF, "R4"); step(0, 5, 0, "R4"); // 0x30 after AND
        // supply low on program
        vpp_ok = 1'b0;
        wr(0, 8'h40, "R6"); wr(6, 8'h00, "R6"); idle(3, "R6 R3");
        vpp_ok = 1'b1;
        wr(0, 8'hFF, "R6"); step(0, 6, 0, "R6"); idle(3, "R11");
        wr(0, 8'h70, "R11"); idle(2, "R11");
        wr(0, 8'h50, "R11"); idle(2, "R11");
        // erase block 0
        wr(0, 8'h20, "R7"); wr(2, 8'hD0, "R7"); idle(ECYC + 2, "R7 R3");
        wr(0, 8'hFF, "R7"); step(0, 5, 0, "R7"); idle(4, "R7");
        // supply low on confirm
        vpp_ok = 1'b0;
        wr(0, 8'h20, "R8"); wr(0, 8'hD0, "R8"); idle(2, "R8");
        vpp_ok = 1'b1;
        wr(0, 8'h50, "R11"); idle(1, "R11");
        // broken erase sequence
        wr(0, 8'h20, "R9"); wr(0, 8'h33, "R9"); idle(2, "R9");
        wr(0, 8'h50, "R11"); idle(1, "R11");
        // injected faults
        fault_inject = 1'b1;
        wr(0, 8'h40, "R10"); wr(9, 8'h0F, "R10"); idle(PCYC + 1, "R10");
        wr(0, 8'h50, "R10"); idle(1, "R10");
        wr(0, 8'h20, "R10"); wr(16, 8'hD0, "R10"); idle(ECYC + 1, "R10");
        fault_inject = 1'b0;
        wr(0, 8'h50, "R11"); wr(0, 8'hFF, "R10"); idle(4, "R10");
        // suspend and resume
        wr(0, 8'h40, "R12"); wr(8'h25, 8'h11, "R12"); idle(PCYC + 1, "R12");
        wr(0, 8'h40, "R12"); wr(8'h05, 8'h22, "R12"); idle(PCYC + 1, "R12");
        wr(0, 8'h20, "R12"); wr(1, 8'hD0, "R12"); idle(3, "R12");
        wr(0, 8'hB0, "R12"); idle(4, "R12");
        wr(0, 8'hFF, "R12"); step(0, 8'h25, 0, "R12"); step(0, 8'h05, 0, "R12");
        wr(0, 8'h40, "R12"); wr(0, 8'h50, "R12"); wr(0, 8'h20, "R12");
        step(0, 8'h25, 0, "R12"); step(0, 8'h06, 0, "R12");
        wr(0, 8'h70, "R12"); idle(2, "R12");
        wr(0, 8'hD0, "R12"); idle(ECYC, "R12");
        wr(0, 8'hFF, "R12"); step(0, 8'h05, 0, "R12"); step(0, 8'h25, 0, "R12");
        idle(4, "R2");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule